// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a fixed set of sources and hands them to a processor one at a time. Sources may stand for arithmetic faults such as overflow or division by zero, a periodic timer, completion or error reports from peripherals, and hardware faults such as a power loss. Any request pulse makes that source pending, and it stays pending until the processor acknowledges it. The controller raises a single interrupt line and shows the identity of the chosen source. The processor acknowledges the request when it starts the handler and signals end-of-service when the handler finishes.

Two service policies are chosen with one mode input. The first is a first-come policy: while any handler is running, nothing new is delivered. Requests still collect, and they are delivered in the order they arrived. The second is a pre-emptive policy. A source with a higher index may interrupt a running handler of lower index. When that handler ends, service falls back to the level it interrupted. For example, suppose a printer (source 1) requests first, then a communication line (source 3), then a disk (source 2). The first-come policy serves them in the order 1, 3, 2. The pre-emptive policy lets the line interrupt the printer, holds the disk back until the line is done, and then lets the disk interrupt the printer.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After an active-low reset, whether applied at power-up or mid-run, `irq_o` is 0, `irq_id_o` is 0, and no earlier request is ever delivered.
- R2: A request sampled at a clock edge makes its source pending. When the request is deliverable, `irq_o` rises with its index on `irq_id_o` after the following edge, two edges after the request.
- R3: While `irq_o` is 1 and no acknowledge arrives, `irq_o` and `irq_id_o` stay unchanged. `irq_id_o` changes only when a new interrupt is presented. An acknowledge while `irq_o` is 0 has no effect.
- R4: An acknowledge while `irq_o` is 1 drops `irq_o` at the next edge, clears that source's pending state and puts the source in service.
- R5: In first-come mode (`nest_mode_i` = 0), nothing is delivered while any source is in service. Requests that arrive meanwhile stay pending and are delivered once service ends.
- R6: In first-come mode, pending sources are delivered in arrival order. Sources whose requests arrive in the same cycle are ordered lowest index first.
- R7: In pre-emptive mode (`nest_mode_i` = 1), a pending source whose index is above the highest source in service is delivered while that service is still running.
- R8: In pre-emptive mode, a pending source whose index is below or equal to the highest source in service is not delivered.
- R9: End-of-service removes the highest source in service. The next-highest source in service becomes the level that later requests are compared against.
- R10: If a source requests again in the same cycle as its own acknowledge, it stays pending and is delivered again later.
- R11: End-of-service with no source in service has no effect, even in the same cycle as an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NSRC | One request bit per source; a high sample marks the source pending |
| nest_mode_i | input | 1 | 0 = first-come policy, 1 = pre-emptive policy |
| ack_i | input | 1 | Processor accepts the presented interrupt |
| eos_i | input | 1 | Processor finished the current handler |
| irq_o | output | 1 | Interrupt presented to the processor |
| irq_id_o | output | clog2(NSRC) | Index of the presented source |

## Verification
Two coincidences get their own test. In the first, an acknowledge falls in the same cycle as a new request from the same source. The bench then expects the source to stay pending: it is held back while its earlier instance is in service and is delivered a second time after end-of-service. In the second, an acknowledge lands together with an end-of-service while nothing is in service. The bench judges this case by sending a later request and checking that the first-come policy still blocks it until one more end-of-service. The pre-emptive walk through the printer, line and disk arrivals also checks delivery decisions that depend on an end-of-service from the cycle before.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    typedef enum logic {
        POLICY_FIFO = 1'b0,
        POLICY_NEST = 1'b1
    } policy_e;
endpackage

// File: rtl/irq_hi_pick.sv
module irq_hi_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_order_q.sv
module irq_order_q #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  push_i,
    input  logic          rm_en_i,
    input  logic [IW-1:0] rm_id_i,
    output logic          head_vld_o,
    output logic [IW-1:0] head_id_o
);
    localparam int CW = $clog2(N + 1);
    localparam int AW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] NCAP = CW'(N);

    typedef struct packed {
        logic [N-1:0][IW-1:0] ent;
        logic [CW-1:0]        cnt;
    } oq_t;

    oq_t s_q, s_d;

    always_comb begin
        logic [CW-1:0] k;
        s_d.ent = '0;
        k       = '0;
        // keep older entries in order, dropping the acknowledged one
        for (int i = 0; i < N; i++) begin
            if ((CW'(i) < s_q.cnt) && !(rm_en_i && (s_q.ent[i] == rm_id_i))) begin
                s_d.ent[k[AW-1:0]] = s_q.ent[i];
                k = k + CW'(1);
            end
        end
        // append this cycle's arrivals, lowest index first
        for (int j = 0; j < N; j++) begin
            if (push_i[j] && (k < NCAP)) begin
                s_d.ent[k[AW-1:0]] = IW'(j);
                k = k + CW'(1);
            end
        end
        s_d.cnt = k;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_vld_o = (s_q.cnt != '0);
    assign head_id_o  = s_q.ent[0];
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en_i,
    input  logic [IW-1:0] set_id_i,
    input  logic          end_i,
    output logic          busy_o,
    output logic [IW:0]   top_lvl_o
);
    localparam int LW = IW + 1;

    typedef struct packed {
        logic [N-1:0] mask;
    } svc_t;

    svc_t          s_q, s_d;
    logic          top_found;
    logic [IW-1:0] top_idx;

    irq_hi_pick #(.N(N), .IW(IW)) u_top (
        .vec_i   (s_q.mask),
        .found_o (top_found),
        .idx_o   (top_idx)
    );

    always_comb begin
        s_d = s_q;
        if (end_i && top_found) s_d.mask[top_idx] = 1'b0;
        if (set_en_i)           s_d.mask[set_id_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o    = top_found;
    assign top_lvl_o = top_found ? (LW'(top_idx) + LW'(1)) : '0;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NSRC = 4,
    localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            nest_mode_i,
    input  logic            ack_i,
    input  logic            eos_i,
    output logic            irq_o,
    output logic [IW-1:0]   irq_id_o
);
    import prio_irq_pkg::*;

    localparam int LW = IW + 1;

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic            irq;
        logic [IW-1:0]   id;
    } ctl_t;

    ctl_t            s_q, s_d;
    policy_e         policy;
    logic            ack_take;
    logic [NSRC-1:0] ack_mask, pend_live, push;
    logic            head_vld, busy, hp_found, deliver;
    logic [IW-1:0]   head_id, hp_idx, sel_id;
    logic [IW:0]     top_lvl;

    assign policy    = policy_e'(nest_mode_i);
    assign ack_take  = s_q.irq & ack_i;
    assign ack_mask  = ack_take ? (NSRC'(1) << s_q.id) : '0;
    assign pend_live = s_q.pend & ~ack_mask;
    assign push      = req_i & ~pend_live;

    irq_order_q #(.N(NSRC), .IW(IW)) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .rm_en_i    (ack_take),
        .rm_id_i    (s_q.id),
        .head_vld_o (head_vld),
        .head_id_o  (head_id)
    );

    irq_svc_track #(.N(NSRC), .IW(IW)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en_i  (ack_take),
        .set_id_i  (s_q.id),
        .end_i     (eos_i),
        .busy_o    (busy),
        .top_lvl_o (top_lvl)
    );

    irq_hi_pick #(.N(NSRC), .IW(IW)) u_pend_pick (
        .vec_i   (s_q.pend),
        .found_o (hp_found),
        .idx_o   (hp_idx)
    );

    always_comb begin
        deliver = 1'b0;
        sel_id  = head_id;
        case (policy)
            POLICY_FIFO: begin
                deliver = head_vld && !busy;
                sel_id  = head_id;
            end
            POLICY_NEST: begin
                deliver = hp_found && ((LW'(hp_idx) + LW'(1)) > top_lvl);
                sel_id  = hp_idx;
            end
            default: begin
                deliver = 1'b0;
                sel_id  = head_id;
            end
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.pend = pend_live | req_i;
        if (s_q.irq) begin
            if (ack_take) s_d.irq = 1'b0;
        end else if (deliver) begin
            s_d.irq = 1'b1;
            s_d.id  = sel_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o    = s_q.irq;
    assign irq_id_o = s_q.id;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int NSRC = 4,
    parameter int IW   = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nest_mode_i,
    input logic          ack_i,
    input logic          eos_i,
    input logic          irq_o,
    input logic [IW-1:0] irq_id_o
);
    localparam int DW = $clog2(NSRC + 1);

    logic [DW-1:0] dep_q, dep_d;

    // count of handlers in service, rebuilt from the port handshake
    always_comb begin
        dep_d = dep_q;
        if (eos_i && (dep_d != '0)) dep_d = dep_d - DW'(1);
        if (ack_i && irq_o)         dep_d = dep_d + DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dep_q <= '0;
        else        dep_q <= dep_d;
    end

    assert_id_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(irq_id_o)));

    assert_idle_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |=> (irq_o || $stable(irq_id_o)));

    assert_ack_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

    assert_fifo_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_mode_i && (dep_q != '0) && !irq_o) |=> !irq_o);
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.NSRC(NSRC), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nest_mode_i (nest_mode_i),
    .ack_i       (ack_i),
    .eos_i       (eos_i),
    .irq_o       (irq_o),
    .irq_id_o    (irq_id_o)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req;
    logic       nest, ack, eos;
    logic       irq;
    logic [1:0] id;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done  = 1'b0;

    always #5 clk = ~clk;

    prio_irq_ctrl #(.NSRC(4)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .nest_mode_i (nest),
        .ack_i       (ack),
        .eos_i       (eos),
        .irq_o       (irq),
        .irq_id_o    (id)
    );

    // row: mode | req[3:0] | ack | eos | exp irq | exp id[1:0] | req tag
    // sources: 1 printer, 2 disk, 3 line (priority rises with index)
    localparam logic [13:0] VEC [0:56] = '{
        14'b0_0010_0_0_0_00_0010, // R2 printer arrives
        14'b0_0000_0_0_1_01_0010, // R2 presented
        14'b0_0000_0_0_1_01_0011, // R3 held
        14'b0_0000_1_0_0_01_0100, // R4 ack
        14'b0_1000_0_0_0_01_0101, // R5 line waits
        14'b0_0100_0_0_0_01_0101, // R5 disk waits
        14'b0_0000_0_0_0_01_0101, // R5
        14'b0_0000_0_1_0_01_0101, // R5 end printer
        14'b0_0000_0_0_1_11_0110, // R6 line first
        14'b0_0000_1_0_0_11_0100, // R4
        14'b0_0000_0_1_0_11_0101, // R5
        14'b0_0000_0_0_1_10_0110, // R6 disk
        14'b0_0000_1_0_0_10_0100, // R4
        14'b0_0000_0_1_0_10_0101, // R5
        14'b0_0000_0_0_0_10_0100, // R4 nothing left
        14'b0_1001_0_0_0_10_0110, // R6 src0 and src3 together
        14'b0_0010_0_0_1_00_0110, // R6 lowest index first
        14'b0_0000_1_0_0_00_0100, // R4
        14'b0_0000_0_1_0_00_0101, // R5
        14'b0_0000_0_0_1_11_0110, // R6
        14'b0_0000_1_0_0_11_0100, // R4
        14'b0_0000_0_1_0_11_0101, // R5
        14'b0_0000_0_0_1_01_0110, // R6 later arrival last
        14'b0_0000_1_1_0_01_1011, // R11 ack with idle end
        14'b0_0100_0_0_0_01_1011, // R11 still in service
        14'b0_0000_0_0_0_01_1011, // R11
        14'b0_0000_0_1_0_01_1011, // R11
        14'b0_0000_0_0_1_10_1011, // R11
        14'b0_0000_1_0_0_10_0100, // R4
        14'b0_0000_0_1_0_10_0101, // R5
        14'b0_0000_0_0_0_10_0100, // R4
        14'b1_0010_0_0_0_10_0010, // R2 nested printer
        14'b1_0000_0_0_1_01_0111, // R7
        14'b1_0000_1_0_0_01_0100, // R4
        14'b1_1000_0_0_0_01_0111, // R7 line arrives
        14'b1_0000_0_0_1_11_0111, // R7 pre-empts
        14'b1_0100_1_0_0_11_1000, // R8 disk arrives
        14'b1_0000_0_0_0_11_1000, // R8 disk held
        14'b1_0000_0_1_0_11_1001, // R9 end line
        14'b1_0000_0_0_1_10_1001, // R9 disk over printer
        14'b1_0000_1_0_0_10_0100, // R4
        14'b1_0000_0_1_0_10_1001, // R9
        14'b1_0000_0_1_0_10_1001, // R9
        14'b1_0000_0_0_0_10_1001, // R9
        14'b1_0100_0_0_0_10_1000, // R8
        14'b1_0000_0_0_1_10_1000, // R8
        14'b1_0000_1_0_0_10_0100, // R4
        14'b1_0101_0_0_0_10_1000, // R8 equal and lower
        14'b1_0000_0_0_0_10_1000, // R8 equal waits
        14'b1_0000_0_1_0_10_1000, // R8
        14'b1_0000_0_0_1_10_1000, // R8
        14'b1_0000_1_0_0_10_0100, // R4
        14'b1_0000_0_1_0_10_1001, // R9
        14'b1_0000_0_0_1_00_1001, // R9
        14'b1_0000_1_0_0_00_0100, // R4
        14'b1_0000_0_1_0_00_1001, // R9
        14'b1_0000_0_0_0_00_1001  // R9
    };

    task automatic chk(input logic xi, input logic [1:0] xd, input string tag);
        n_chk++;
        if (irq !== xi || id !== xd) begin
            n_err++;
            $display("FAIL %s: got irq=%0b id=%0d, expected irq=%0b id=%0d",
                     tag, irq, id, xi, xd);
        end
    endtask

    task automatic cyc(input logic n, input logic [3:0] r, input logic a, input logic e);
        nest = n; req = r; ack = a; eos = e;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; req = '0; nest = 1'b0; ack = 1'b0; eos = 1'b0;
        repeat (3) @(negedge clk);
        chk(1'b0, 2'd0, "R1 in reset");
        rst_n = 1'b1;
        cyc(1'b0, 4'b0000, 1'b0, 1'b0);
        chk(1'b0, 2'd0, "R1 after reset");

        for (int k = 0; k < 57; k++) begin
            logic [13:0] v;
            v = VEC[k];
            cyc(v[13], v[12:9], v[8], v[7]);
            chk(v[6], v[5:4], $sformatf("R%0d row %0d", v[3:0], k));
        end

        // R10: re-request in the acknowledge cycle
        cyc(1'b0, 4'b0010, 1'b0, 1'b0); chk(1'b0, 2'd0, "R10");
        cyc(1'b0, 4'b0000, 1'b0, 1'b0); chk(1'b1, 2'd1, "R10");
        cyc(1'b0, 4'b0010, 1'b1, 1'b0); chk(1'b0, 2'd1, "R10");
        cyc(1'b0, 4'b0000, 1'b0, 1'b0); chk(1'b0, 2'd1, "R10");
        cyc(1'b0, 4'b0000, 1'b0, 1'b1); chk(1'b0, 2'd1, "R10");
        cyc(1'b0, 4'b0000, 1'b0, 1'b0); chk(1'b1, 2'd1, "R10");
        cyc(1'b0, 4'b0000, 1'b1, 1'b0); chk(1'b0, 2'd1, "R4");
        cyc(1'b0, 4'b0000, 1'b0, 1'b1); chk(1'b0, 2'd1, "R5");

        // R3: acknowledge without a presented interrupt is ignored
        cyc(1'b0, 4'b0000, 1'b1, 1'b0); chk(1'b0, 2'd1, "R3");
        cyc(1'b0, 4'b1000, 1'b0, 1'b0); chk(1'b0, 2'd1, "R3");
        cyc(1'b0, 4'b0000, 1'b0, 1'b0); chk(1'b1, 2'd3, "R3");
        cyc(1'b0, 4'b0000, 1'b1, 1'b0); chk(1'b0, 2'd3, "R4");
        cyc(1'b0, 4'b0000, 1'b0, 1'b1); chk(1'b0, 2'd3, "R5");

        // R1: reset mid-run discards a pending request
        cyc(1'b0, 4'b0100, 1'b0, 1'b0); chk(1'b0, 2'd3, "R2");
        rst_n = 1'b0;
        cyc(1'b0, 4'b0000, 1'b0, 1'b0); chk(1'b0, 2'd0, "R1");
        rst_n = 1'b1;
        cyc(1'b0, 4'b0000, 1'b0, 1'b0); chk(1'b0, 2'd0, "R1");
        cyc(1'b0, 4'b0000, 1'b0, 1'b0); chk(1'b0, 2'd0, "R1");
        cyc(1'b1, 4'b0000, 1'b0, 1'b0); chk(1'b0, 2'd0, "R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule